// File: doc/BRIEF.md
# Lane Direction Turnaround Sequencer

This block runs the handshake that hands ownership of one bidirectional low-power lane from one end to the other. The end that holds the lane sits in Stop and drives LP-11. On a host request it walks through a fixed five-step line pattern, lets go of its driver, and waits for the far end to answer. The far end watches the line. Once it has seen the whole request pattern it switches its own driver on and sends the acknowledge pattern. After that it holds the lane, in Stop.

The same block serves both roles, so two copies, one at each end of a lane, pass the lane back and forth. Each driven step lasts a programmable number of clocks. A programmable watchdog limits how long the releasing side waits for the answer. A power-down input blocks new requests. A direction output tells which side owns the lane.

Top module: `lane_turnaround`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block with the default owner setting drives LP-11 (`drv_out` = 2'b11, encoded as {positive wire, negative wire}) with `drv_en` = 1 and `own_lane` = 1.
- R2: In Stop, a cycle with `tat_req` = 1 and `pwr_down` = 0 starts the request. From the next cycle `drv_out` shows 2'b11, 2'b10, 2'b00, 2'b10, 2'b00 in that order, each for P clocks, and `drv_en` stays 1.
- R3: `tat_req` has no effect while `pwr_down` = 1, and it has no effect while a request pattern is being driven.
- R4: After the last request step, `drv_en` drops to 0 while `own_lane` stays 1. The cycle after `line_in` is sampled as 2'b11, `own_lane` is 0 and the driver stays off.
- R5: If `line_in` does not show 2'b11 within `wd_limit`+1 cycles after release, the block returns to Stop and drives 2'b11 with `drv_en` = 1.
- R6: As receiver, once it has been armed by 2'b11 and then sees the line change to 2'b10, 2'b00, 2'b10 and 2'b00 in turn, the block drives 2'b00 from the next cycle for P clocks, then 2'b10 for P clocks, with `drv_en` = 1 and `own_lane` = 1, and then enters Stop driving 2'b11.
- R7: As receiver, a line change that breaks the pattern (an unexpected value, or a return to 2'b11) discards the partial match. After a break, no pattern counts until 2'b11 has been seen again. The driver stays off meanwhile.
- R8: P equals `phase_clks`, and a value of 0 is treated as 1.
- R9: `drv_en` is never 1 while `own_lane` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tat_req | input | 1 | Host request to hand the lane over |
| pwr_down | input | 1 | Power-down; blocks requests |
| phase_clks | input | PHASE_W | Clocks per driven step (0 is treated as 1) |
| wd_limit | input | WD_W | Watchdog limit while waiting for the answer |
| line_in | input | 2 | Sampled lane state {positive, negative} |
| drv_out | output | 2 | Value driven onto the lane |
| drv_en | output | 1 | Low-power driver enable (0 = high impedance) |
| own_lane | output | 1 | 1 when this side owns the lane |

## Verification
The assertions assume that `line_in` is already synchronized to `clk` and holds each level for at least one cycle. They also assume that `phase_clks` and `wd_limit` change only while the block is in Stop. The bench plays the far end directly on `line_in`. It reprograms the step length only in Stop, and it keeps the line at one level per cycle. The receiver scenarios include a broken pattern and an early return to LP-11 before the complete pattern.

// File: rtl/lane_tat_pkg.sv
package lane_tat_pkg;

    typedef logic [1:0] lp_t;

    localparam lp_t LP11 = 2'b11;
    localparam lp_t LP10 = 2'b10;
    localparam lp_t LP00 = 2'b00;

    localparam int REQ_STEPS    = 5;
    localparam int ACK_STEPS    = 2;
    localparam int RX_MATCH_LEN = REQ_STEPS - 1;
    localparam int STEP_W       = $clog2(REQ_STEPS);

    typedef enum logic [2:0] {
        ST_STOP    = 3'd0,
        ST_TXSEQ   = 3'd1,
        ST_RELEASE = 3'd2,
        ST_RX      = 3'd3,
        ST_ACK     = 3'd4
    } tat_state_e;

    typedef struct packed {
        logic en;
        lp_t  val;
        logic own;
    } drive_t;

    function automatic lp_t req_pattern(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd0:    return LP11;
            3'd1:    return LP10;
            3'd2:    return LP00;
            3'd3:    return LP10;
            3'd4:    return LP00;
            default: return LP11;
        endcase
    endfunction

    function automatic lp_t rx_expect(input logic [1:0] idx);
        return req_pattern({1'b0, idx} + 3'd1);
    endfunction

    function automatic lp_t ack_pattern(input logic [STEP_W-1:0] idx);
        return (idx == '0) ? LP00 : LP10;
    endfunction

endpackage

// File: rtl/lane_tat_counter.sv
module lane_tat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] cnt_q;

    assign at_limit = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (!at_limit) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/lane_tat_req_matcher.sv
module lane_tat_req_matcher
    import lane_tat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  lp_t  line_in,
    output logic hit
);
    lp_t        prev_q;
    logic       armed_q;
    logic [1:0] idx_q;
    logic       changed;
    logic       match;

    assign changed = (line_in != prev_q);
    assign match   = (line_in == rx_expect(idx_q));
    assign hit     = en && armed_q && changed && match
                     && (idx_q == 2'(RX_MATCH_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= LP11;
            armed_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            prev_q <= line_in;
            if (!en) begin
                armed_q <= 1'b0;
                idx_q   <= '0;
            end else if (line_in == LP11) begin
                armed_q <= 1'b1;
                idx_q   <= '0;
            end else if (armed_q && changed) begin
                if (hit) begin
                    armed_q <= 1'b0;
                    idx_q   <= '0;
                end else if (match) begin
                    idx_q <= idx_q + 2'd1;
                end else begin
                    armed_q <= 1'b0;
                    idx_q   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/lane_tat_drive_map.sv
module lane_tat_drive_map
    import lane_tat_pkg::*;
(
    input  tat_state_e        st,
    input  logic [STEP_W-1:0] step,
    output drive_t            drv
);
    always_comb begin
        drv = '{en: 1'b0, val: LP00, own: 1'b0};
        case (st)
            ST_STOP:    drv = '{en: 1'b1, val: LP11, own: 1'b1};
            ST_TXSEQ:   drv = '{en: 1'b1, val: req_pattern(step), own: 1'b1};
            ST_RELEASE: drv = '{en: 1'b0, val: LP00, own: 1'b1};
            ST_ACK:     drv = '{en: 1'b1, val: ack_pattern(step), own: 1'b1};
            default:    drv = '{en: 1'b0, val: LP00, own: 1'b0};
        endcase
    end
endmodule

// File: rtl/lane_turnaround.sv
module lane_turnaround
    import lane_tat_pkg::*;
#(
    parameter int   PHASE_W    = 8,
    parameter int   WD_W       = 16,
    parameter logic INIT_OWNER = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tat_req,
    input  logic               pwr_down,
    input  logic [PHASE_W-1:0] phase_clks,
    input  logic [WD_W-1:0]    wd_limit,
    input  logic [1:0]         line_in,
    output logic [1:0]         drv_out,
    output logic               drv_en,
    output logic               own_lane
);
    localparam tat_state_e RESET_ST = INIT_OWNER ? ST_STOP : ST_RX;
    localparam logic [STEP_W-1:0] REQ_LAST = STEP_W'(REQ_STEPS - 1);
    localparam logic [STEP_W-1:0] ACK_LAST = STEP_W'(ACK_STEPS - 1);

    tat_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [PHASE_W-1:0] phase_lim;
    logic              in_phase;
    logic              ph_last;
    logic              wd_last;
    logic              rx_hit;
    logic              start_tx;
    drive_t            drv;

    assign phase_lim = (phase_clks == '0) ? '0 : phase_clks - PHASE_W'(1);
    assign in_phase  = (state_q == ST_TXSEQ) || (state_q == ST_ACK);
    assign start_tx  = (state_q == ST_STOP) && tat_req && !pwr_down;

    lane_tat_counter #(.W(PHASE_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .clr      (!in_phase || ph_last),
        .limit    (phase_lim),
        .at_limit (ph_last)
    );

    lane_tat_counter #(.W(WD_W)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .clr      (state_q != ST_RELEASE),
        .limit    (wd_limit),
        .at_limit (wd_last)
    );

    lane_tat_req_matcher u_match (
        .clk     (clk),
        .rst     (rst),
        .en      (state_q == ST_RX),
        .line_in (line_in),
        .hit     (rx_hit)
    );

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        case (state_q)
            ST_STOP: begin
                if (start_tx) begin
                    state_d = ST_TXSEQ;
                    step_d  = '0;
                end
            end
            ST_TXSEQ: begin
                if (ph_last) begin
                    if (step_q == REQ_LAST) begin
                        state_d = ST_RELEASE;
                        step_d  = '0;
                    end else begin
                        step_d = step_q + STEP_W'(1);
                    end
                end
            end
            ST_RELEASE: begin
                if (line_in == LP11) begin
                    state_d = ST_RX;
                end else if (wd_last) begin
                    state_d = ST_STOP;
                end
            end
            ST_RX: begin
                if (rx_hit) begin
                    state_d = ST_ACK;
                    step_d  = '0;
                end
            end
            ST_ACK: begin
                if (ph_last) begin
                    if (step_q == ACK_LAST) begin
                        state_d = ST_STOP;
                        step_d  = '0;
                    end else begin
                        step_d = step_q + STEP_W'(1);
                    end
                end
            end
            default: begin
                state_d = RESET_ST;
                step_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_ST;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    lane_tat_drive_map u_map (
        .st   (state_q),
        .step (step_q),
        .drv  (drv)
    );

    assign drv_out  = drv.val;
    assign drv_en   = drv.en;
    assign own_lane = drv.own;
endmodule

// File: rtl/lane_turnaround_checker.sv
module lane_turnaround_checker
    import lane_tat_pkg::*;
#(
    parameter int   WD_W       = 16,
    parameter logic INIT_OWNER = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            tat_req,
    input logic            pwr_down,
    input logic [WD_W-1:0] wd_limit,
    input logic [1:0]      line_in,
    input logic [1:0]      drv_out,
    input logic            drv_en,
    input logic            own_lane,
    input tat_state_e      st
);
    logic [WD_W:0] rel_cnt;

    always_ff @(posedge clk) begin
        if (rst || st != ST_RELEASE) begin
            rel_cnt <= '0;
        end else begin
            rel_cnt <= rel_cnt + (WD_W + 1)'(1);
        end
    end

    p_reset_owner_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (own_lane == INIT_OWNER) && (drv_en == INIT_OWNER));

    p_req_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP && tat_req && !pwr_down) |=> (st == ST_TXSEQ && drv_en && drv_out == LP11));

    p_pd_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP && pwr_down) |=> (st == ST_STOP));

    p_release_off_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RELEASE) |-> (!drv_en && own_lane));

    p_handover_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RELEASE && line_in == LP11) |=> (!own_lane && !drv_en));

    p_wd_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RELEASE) |-> ({1'b0, wd_limit} >= rel_cnt));

    p_ack_first_r6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_RX && $past(st) == ST_RX) |-> (drv_en && drv_out == LP00 && own_lane));

    p_drive_needs_owner_r9: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> own_lane);
endmodule

bind lane_turnaround lane_turnaround_checker #(
    .WD_W       (WD_W),
    .INIT_OWNER (INIT_OWNER)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tat_req  (tat_req),
    .pwr_down (pwr_down),
    .wd_limit (wd_limit),
    .line_in  (line_in),
    .drv_out  (drv_out),
    .drv_en   (drv_en),
    .own_lane (own_lane),
    .st       (state_q)
);

// File: tb/lane_turnaround_bench.sv
module lane_turnaround_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tat_req = 1'b0;
    logic       pwr_down = 1'b0;
    logic [7:0] phase_clks = 8'd3;
    logic [15:0] wd_limit = 16'd5;
    logic [1:0] line_in = 2'b11;
    logic [1:0] drv_out;
    logic       drv_en;
    logic       own_lane;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [1:0] tx_pat [5] = '{2'b11, 2'b10, 2'b00, 2'b10, 2'b00};

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_turnaround u_lane_turnaround (
        .clk        (clk),
        .rst        (rst),
        .tat_req    (tat_req),
        .pwr_down   (pwr_down),
        .phase_clks (phase_clks),
        .wd_limit   (wd_limit),
        .line_in    (line_in),
        .drv_out    (drv_out),
        .drv_en     (drv_en),
        .own_lane   (own_lane)
    );

    // Compare the outputs of the current cycle, then apply the inputs for the next edge.
    task automatic cyc(input logic rq, input logic [1:0] ln, input logic e_en,
                       input logic [1:0] e_out, input logic e_own, input string tag);
        n_cmp++;
        if (drv_en !== e_en || drv_out !== e_out || own_lane !== e_own) begin
            n_bad++;
            $display("FAIL %s: got en=%0b out=%b own=%0b, expected en=%0b out=%b own=%0b",
                     tag, drv_en, drv_out, own_lane, e_en, e_out, e_own);
        end
        tat_req = rq;
        line_in = ln;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_cyc(input int n, input logic rq, input string tag);
        for (int i = 0; i < n; i++) cyc(rq, 2'b11, 1'b1, 2'b11, 1'b1, tag);
    endtask

    task automatic rx_cyc(input int n, input logic [1:0] ln, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, ln, 1'b0, 2'b00, 1'b0, tag);
    endtask

    task automatic tx_seq(input int p, input logic rq, input string tag);
        int pe;
        pe = (p == 0) ? 1 : p;
        for (int k = 0; k < 5; k++)
            for (int c = 0; c < pe; c++)
                cyc(rq, tx_pat[k], 1'b1, tx_pat[k], 1'b1, tag);
    endtask

    task automatic ack_seq(input int p, input string tag);
        int pe;
        pe = (p == 0) ? 1 : p;
        for (int c = 0; c < pe; c++) cyc(1'b0, 2'b00, 1'b1, 2'b00, 1'b1, tag);
        for (int c = 0; c < pe; c++) cyc(1'b0, 2'b10, 1'b1, 2'b10, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        stop_cyc(2, 1'b0, "R1");

        // R3: requests blocked by power-down
        pwr_down = 1'b1;
        stop_cyc(3, 1'b1, "R3");
        pwr_down = 1'b0;
        stop_cyc(1, 1'b0, "R3");

        // R2: request pattern; R3: request held during the pattern is ignored
        stop_cyc(1, 1'b1, "R2");
        tx_seq(3, 1'b1, "R2");
        // R4: release, overlap, answer, handover
        cyc(1'b0, 2'b00, 1'b0, 2'b00, 1'b1, "R4");
        cyc(1'b0, 2'b00, 1'b0, 2'b00, 1'b1, "R4");
        cyc(1'b0, 2'b10, 1'b0, 2'b00, 1'b1, "R4");
        cyc(1'b0, 2'b10, 1'b0, 2'b00, 1'b1, "R4");
        cyc(1'b0, 2'b11, 1'b0, 2'b00, 1'b1, "R4");
        rx_cyc(1, 2'b11, "R4");

        // R7: broken pattern, no re-match until LP-11, early return to LP-11
        rx_cyc(2, 2'b11, "R7");
        rx_cyc(2, 2'b10, "R7");
        rx_cyc(2, 2'b01, "R7");
        rx_cyc(1, 2'b00, "R7");
        rx_cyc(1, 2'b10, "R7");
        rx_cyc(2, 2'b00, "R7");
        rx_cyc(1, 2'b10, "R7");
        rx_cyc(1, 2'b00, "R7");
        rx_cyc(2, 2'b11, "R7");
        rx_cyc(1, 2'b10, "R7");
        rx_cyc(1, 2'b00, "R7");
        rx_cyc(2, 2'b11, "R7");

        // R6: full request seen, acknowledge, then Stop
        rx_cyc(3, 2'b10, "R6");
        rx_cyc(3, 2'b00, "R6");
        rx_cyc(3, 2'b10, "R6");
        rx_cyc(1, 2'b00, "R6");
        ack_seq(3, "R6");
        stop_cyc(2, 1'b0, "R6");

        // R5: no answer, watchdog returns to Stop after wd_limit+1 cycles
        stop_cyc(1, 1'b1, "R5");
        tx_seq(3, 1'b0, "R5");
        for (int i = 0; i < 6; i++) cyc(1'b0, 2'b00, 1'b0, 2'b00, 1'b1, "R5");
        stop_cyc(2, 1'b0, "R5");

        // R8: zero step length behaves as one clock
        phase_clks = 8'd0;
        stop_cyc(1, 1'b1, "R8");
        tx_seq(0, 1'b0, "R8");
        cyc(1'b0, 2'b11, 1'b0, 2'b00, 1'b1, "R8");
        rx_cyc(1, 2'b11, "R8");
        rx_cyc(1, 2'b10, "R8");
        rx_cyc(1, 2'b00, "R8");
        rx_cyc(1, 2'b10, "R8");
        rx_cyc(1, 2'b00, "R8");
        ack_seq(0, "R8");
        stop_cyc(2, 1'b0, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion within limit");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule